// File: doc/BRIEF.md
# Load Queue Ordering Violation Detector

This block tracks the loads an out-of-order core has already issued, together with the bytes each load reads and its program-order age. Every new load or store that issues is checked against the tracked loads. The check looks for a queued load that comes later in program order and reads at least one byte that the issuing instruction touches. A queued load like that ran too early. The block reports it as a replay trap, so the pipeline can discard that load and everything younger and fetch again from it.

Addresses are given as an aligned quadword number plus an 8-bit byte-enable mask. Ages are sequence numbers that wrap, and they are compared modulo their width. When several queued loads violate at once, the trap names the oldest of them. A load that arrives while the queue is full is not tracked. It is replayed immediately on a separate output, and the incoming instruction is the one named. Retire frees an entry by age. A flush input removes the trapped load and every younger entry.

Top module: `ldq_order_guard`

## Requirements
- R1: After reset the queue is empty: `lq_full_o`, `rpl_full_o` and `trap_valid_o` are 0.
- R2: An accepted issuing load takes one free entry. `lq_full_o` is 1 exactly when all 16 entries are in use.
- R3: A load issuing in cycle N raises `trap_valid_o` for one cycle in N+1 with `trap_is_st_o`=0 and `trap_age_o` set to the age of a queued younger load with the same quadword address and a nonzero mask overlap.
- R4: A store issuing in cycle N raises the same trap in N+1 with `trap_is_st_o`=1. Stores never occupy an entry.
- R5: No trap is raised when every matching queued load has an age equal to or older than the issuer, when the masks share no bit, or when the quadword addresses differ.
- R6: When several queued loads violate at once, `trap_age_o` is the oldest of them.
- R7: Age A is younger than age B when (A-B) modulo 2^AGE_W is nonzero and has its top bit clear, so ordering holds across the wrap of the counter.
- R8: A load issuing while the queue is full raises `rpl_full_o` in the same cycle with `rpl_age_o` equal to its age. It is neither stored nor compared. A store is never replayed this way.
- R9: A retire frees the valid entry whose age equals `ret_age_i`. A freed entry no longer traps.
- R10: `flush_i` invalidates every entry whose age equals `flush_age_i` or is younger than it. Older entries remain.
- R11: An issue in a cycle with `flush_i` high is ignored: it raises no trap and takes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | An instruction issues this cycle |
| iss_is_store_i | input | 1 | 1 = store, 0 = load |
| iss_qaddr_i | input | QA_W | Aligned quadword address |
| iss_mask_i | input | MASK_W | Byte-enable mask within the quadword |
| iss_age_i | input | AGE_W | Program-order sequence number |
| ret_valid_i | input | 1 | A load retires this cycle |
| ret_age_i | input | AGE_W | Age of the retiring load |
| flush_i | input | 1 | Squash the target and everything younger |
| flush_age_i | input | AGE_W | Age where the squash starts |
| lq_full_o | output | 1 | All entries in use |
| rpl_full_o | output | 1 | Incoming load replayed because the queue is full |
| rpl_age_o | output | AGE_W | Age of the replayed incoming load |
| trap_valid_o | output | 1 | Order-violation replay trap |
| trap_is_st_o | output | 1 | 1 = store-load, 0 = load-load |
| trap_age_o | output | AGE_W | Age of the queued load to refetch from |

## Verification
The main stimulus is a sequence of loads and stores on a single quadword. The mask patterns are chosen so that each issue overlaps a different subset of the queued loads. This separates true overlaps from disjoint masks and younger targets from older ones, and it shows which of several violators gets picked. A second address on its own keeps a mask-only compare from passing as correct. Ages placed on both sides of the counter wrap separate modular ordering from plain numeric ordering. Sequences of retire, flush and fill-to-full then confirm, through later traps or their absence, which entries are still held.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef enum logic {K_LD = 1'b0, K_ST = 1'b1} kind_e;

  // a younger than b, modulo 2^w
  function automatic logic age_younger(logic [31:0] a, logic [31:0] b, int unsigned w);
    logic [31:0] d;
    logic [31:0] m;
    m = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    d = (a - b) & m;
    return (d != 32'd0) && !d[w-1];
  endfunction
endpackage

// File: rtl/lq_cmp_slice.sv
module lq_cmp_slice #(
  parameter int unsigned QA_W   = 37,
  parameter int unsigned MASK_W = 8,
  parameter int unsigned AGE_W  = 6
) (
  input  logic              slot_valid_i,
  input  logic [QA_W-1:0]   slot_qaddr_i,
  input  logic [MASK_W-1:0] slot_mask_i,
  input  logic [AGE_W-1:0]  slot_age_i,
  input  logic [QA_W-1:0]   probe_qaddr_i,
  input  logic [MASK_W-1:0] probe_mask_i,
  input  logic [AGE_W-1:0]  probe_age_i,
  output logic              hit_o
);
  logic same_qw, overlap, younger;

  assign same_qw = (slot_qaddr_i == probe_qaddr_i);
  assign overlap = |(slot_mask_i & probe_mask_i);
  assign younger = lq_pkg::age_younger(32'(slot_age_i), 32'(probe_age_i), AGE_W);
  assign hit_o   = slot_valid_i && same_qw && overlap && younger;
endmodule

// File: rtl/lq_oldest_sel.sv
module lq_oldest_sel #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AGE_W = 6
) (
  input  logic [DEPTH-1:0]            hit_i,
  input  logic [DEPTH-1:0][AGE_W-1:0] age_i,
  output logic                        found_o,
  output logic [AGE_W-1:0]            age_o
);
  always_comb begin
    found_o = 1'b0;
    age_o   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_i[i] && (!found_o ||
          lq_pkg::age_younger(32'(age_o), 32'(age_i[i]), AGE_W))) begin
        found_o = 1'b1;
        age_o   = age_i[i];
      end
    end
  end
endmodule

// File: rtl/lq_free_find.sv
module lq_free_find #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] valid_i,
  output logic [IDX_W-1:0] free_idx_o,
  output logic             full_o
);
  assign full_o = &valid_i;

  always_comb begin
    free_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ldq_order_guard.sv
module ldq_order_guard #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned QA_W   = 37,
  parameter int unsigned MASK_W = 8,
  parameter int unsigned AGE_W  = 6,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic              iss_is_store_i,
  input  logic [QA_W-1:0]   iss_qaddr_i,
  input  logic [MASK_W-1:0] iss_mask_i,
  input  logic [AGE_W-1:0]  iss_age_i,
  input  logic              ret_valid_i,
  input  logic [AGE_W-1:0]  ret_age_i,
  input  logic              flush_i,
  input  logic [AGE_W-1:0]  flush_age_i,
  output logic              lq_full_o,
  output logic              rpl_full_o,
  output logic [AGE_W-1:0]  rpl_age_o,
  output logic              trap_valid_o,
  output logic              trap_is_st_o,
  output logic [AGE_W-1:0]  trap_age_o
);
  import lq_pkg::*;

  logic [DEPTH-1:0]             valid_q;
  logic [DEPTH-1:0][QA_W-1:0]   qaddr_q;
  logic [DEPTH-1:0][MASK_W-1:0] mask_q;
  logic [DEPTH-1:0][AGE_W-1:0]  age_q;

  logic [DEPTH-1:0] hit;
  logic [DEPTH-1:0] kill;
  logic [IDX_W-1:0] free_idx;
  logic             full;
  logic             found;
  logic [AGE_W-1:0] oldest_age;
  kind_e            kind;
  logic             live, do_alloc, do_cmp, det;

  assign kind     = kind_e'(iss_is_store_i);
  assign live     = iss_valid_i && !flush_i;
  assign rpl_full_o = live && (kind == K_LD) && full;
  assign rpl_age_o  = iss_age_i;
  assign do_cmp   = live && !rpl_full_o;
  assign do_alloc = do_cmp && (kind == K_LD);
  assign det      = do_cmp && found;
  assign lq_full_o = full;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    lq_cmp_slice #(.QA_W(QA_W), .MASK_W(MASK_W), .AGE_W(AGE_W)) u_cmp (
      .slot_valid_i  (valid_q[g]),
      .slot_qaddr_i  (qaddr_q[g]),
      .slot_mask_i   (mask_q[g]),
      .slot_age_i    (age_q[g]),
      .probe_qaddr_i (iss_qaddr_i),
      .probe_mask_i  (iss_mask_i),
      .probe_age_i   (iss_age_i),
      .hit_o         (hit[g])
    );

    // retire by exact age; flush at or after flush_age
    assign kill[g] = valid_q[g] && (
        (ret_valid_i && age_q[g] == ret_age_i) ||
        (flush_i && (age_q[g] == flush_age_i ||
                     age_younger(32'(age_q[g]), 32'(flush_age_i), AGE_W))));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        qaddr_q[g] <= '0;
        mask_q[g]  <= '0;
        age_q[g]   <= '0;
      end else if (do_alloc && free_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
        qaddr_q[g] <= iss_qaddr_i;
        mask_q[g]  <= iss_mask_i;
        age_q[g]   <= iss_age_i;
      end else if (kill[g]) begin
        valid_q[g] <= 1'b0;
      end
    end
  end

  lq_oldest_sel #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_sel (
    .hit_i   (hit),
    .age_i   (age_q),
    .found_o (found),
    .age_o   (oldest_age)
  );

  lq_free_find #(.DEPTH(DEPTH)) u_free (
    .valid_i    (valid_q),
    .free_idx_o (free_idx),
    .full_o     (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_valid_o <= 1'b0;
      trap_is_st_o <= 1'b0;
      trap_age_o   <= '0;
    end else begin
      trap_valid_o <= det;
      if (det) begin
        trap_is_st_o <= (kind == K_ST);
        trap_age_o   <= oldest_age;
      end
    end
  end
endmodule

// File: rtl/ldq_order_guard_chk.sv
module ldq_order_guard_chk #(
  parameter int unsigned AGE_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iss_valid_i,
  input logic             iss_is_store_i,
  input logic [AGE_W-1:0] iss_age_i,
  input logic             flush_i,
  input logic             lq_full_o,
  input logic             rpl_full_o,
  input logic             trap_valid_o,
  input logic             trap_is_st_o,
  input logic [AGE_W-1:0] trap_age_o
);
  // R8
  full_rpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpl_full_o |-> (lq_full_o && iss_valid_i && !iss_is_store_i));

  // R3
  trap_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_o |-> ($past(iss_valid_i) && !$past(rpl_full_o)));

  // R4
  trap_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_o |-> (trap_is_st_o == $past(iss_is_store_i)));

  // R5
  trap_younger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_o |-> lq_pkg::age_younger(32'(trap_age_o), 32'($past(iss_age_i)), AGE_W));

  // R11
  flush_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> !trap_valid_o);
endmodule

bind ldq_order_guard ldq_order_guard_chk #(.AGE_W(AGE_W)) u_chk (.*);

// File: tb/sim_ldq_order_guard.sv
`timescale 1ns/1ps
module sim_ldq_order_guard;
  localparam int unsigned QA_W = 37, AGE_W = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic iss_valid = 0, iss_st = 0, ret_valid = 0, flush = 0;
  logic [QA_W-1:0] iss_qa = '0;
  logic [7:0] iss_mask = '0;
  logic [AGE_W-1:0] iss_age = '0, ret_age = '0, flush_age = '0;
  logic full, rpl, trap_v, trap_st;
  logic [AGE_W-1:0] rpl_age, trap_age;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ldq_order_guard u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .iss_valid_i(iss_valid), .iss_is_store_i(iss_st), .iss_qaddr_i(iss_qa),
    .iss_mask_i(iss_mask), .iss_age_i(iss_age),
    .ret_valid_i(ret_valid), .ret_age_i(ret_age),
    .flush_i(flush), .flush_age_i(flush_age),
    .lq_full_o(full), .rpl_full_o(rpl), .rpl_age_o(rpl_age),
    .trap_valid_o(trap_v), .trap_is_st_o(trap_st), .trap_age_o(trap_age)
  );

  typedef struct packed {
    logic       st;
    logic [11:0] qa;
    logic [7:0] mask;
    logic [5:0] age;
    logic       e_trap;
    logic       e_st;
    logic [5:0] e_age;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 12'h100, 8'h0F, 6'd10, 1'b0, 1'b0, 6'd0},   // R2 empty
    '{1'b0, 12'h100, 8'hF0, 6'd12, 1'b0, 1'b0, 6'd0},   // R5 older queued
    '{1'b0, 12'h100, 8'h30, 6'd8,  1'b1, 1'b0, 6'd12},  // R3 load-load
    '{1'b1, 12'h100, 8'h01, 6'd5,  1'b1, 1'b1, 6'd10},  // R4 store-load
    '{1'b1, 12'h100, 8'hFF, 6'd4,  1'b1, 1'b1, 6'd8},   // R6 oldest of 8,10,12
    '{1'b1, 12'h100, 8'hFF, 6'd20, 1'b0, 1'b0, 6'd0},   // R5 all older
    '{1'b0, 12'h101, 8'hFF, 6'd3,  1'b0, 1'b0, 6'd0},   // R5 other quadword
    '{1'b1, 12'h101, 8'h80, 6'd2,  1'b1, 1'b1, 6'd3}    // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    iss_valid = 0; ret_valid = 0; flush = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // drive at negedge, trap is visible at the next negedge
  task automatic issue(input logic st, input logic [11:0] qa, input logic [7:0] m,
                       input logic [5:0] age, input logic e_trap, input logic e_st,
                       input logic [5:0] e_age, input string req);
    @(negedge clk);
    iss_valid = 1; iss_st = st; iss_qa = QA_W'(qa); iss_mask = m; iss_age = age;
    @(negedge clk);
    iss_valid = 0;
    chk({req, " trap"}, 32'(trap_v), 32'(e_trap));
    if (e_trap) begin
      chk({req, " kind"}, 32'(trap_st), 32'(e_st));
      chk({req, " age"}, 32'(trap_age), 32'(e_age));
    end
  endtask

  task automatic retire(input logic [5:0] age);
    @(negedge clk);
    ret_valid = 1; ret_age = age;
    @(negedge clk);
    ret_valid = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1
    chk("R1 full", 32'(full), 0);
    chk("R1 rpl", 32'(rpl), 0);
    chk("R1 trap", 32'(trap_v), 0);

    for (int i = 0; i < NV; i++)
      issue(TBL[i].st, TBL[i].qa, TBL[i].mask, TBL[i].age,
            TBL[i].e_trap, TBL[i].e_st, TBL[i].e_age, $sformatf("R3/R4 vec%0d", i));

    // R7 wrap: 1 is younger than 62
    do_reset();
    issue(0, 12'h040, 8'h01, 6'd62, 0, 0, 0, "R7 first");
    issue(0, 12'h040, 8'h01, 6'd1, 0, 0, 0, "R7 wrap younger no trap");
    issue(1, 12'h040, 8'h01, 6'd61, 1, 1, 6'd62, "R7 R6 oldest across wrap");
    // R9
    retire(6'd62);
    issue(1, 12'h040, 8'h01, 6'd60, 1, 1, 6'd1, "R9 retired entry gone");

    // R10
    do_reset();
    for (int a = 5; a <= 8; a++) issue(0, 12'h200, 8'h01, 6'(a), 0, 0, 0, "R10 fill");
    @(negedge clk);
    flush = 1; flush_age = 6'd7;
    @(negedge clk);
    flush = 0;
    retire(6'd5);
    issue(1, 12'h200, 8'h01, 6'd4, 1, 1, 6'd6, "R10 older kept");
    retire(6'd6);
    issue(1, 12'h200, 8'h01, 6'd4, 0, 0, 0, "R10 younger flushed");

    // R11
    do_reset();
    @(negedge clk);
    flush = 1; flush_age = 6'd0;
    iss_valid = 1; iss_st = 0; iss_qa = QA_W'(12'h300); iss_mask = 8'h01; iss_age = 6'd9;
    @(negedge clk);
    flush = 0; iss_valid = 0;
    chk("R11 no trap in flush", 32'(trap_v), 0);
    issue(1, 12'h300, 8'h01, 6'd8, 0, 0, 0, "R11 not stored");

    // R2 / R8
    do_reset();
    for (int a = 0; a < 15; a++) issue(0, 12'h400 + 12'(a), 8'h01, 6'(a), 0, 0, 0, "R2 fill");
    chk("R2 not full at 15", 32'(full), 0);
    issue(0, 12'h40F, 8'h01, 6'd15, 0, 0, 0, "R2 fill");
    chk("R2 full at 16", 32'(full), 1);
    @(negedge clk);
    iss_valid = 1; iss_st = 0; iss_qa = QA_W'(12'h500); iss_mask = 8'h01; iss_age = 6'd16;
    #1;
    chk("R8 replay", 32'(rpl), 1);
    chk("R8 replay age", 32'(rpl_age), 16);
    iss_st = 1; iss_age = 6'd17;
    #1;
    chk("R8 store not replayed", 32'(rpl), 0);
    @(negedge clk);
    iss_valid = 0;
    retire(6'd0);
    chk("R2 R9 not full after retire", 32'(full), 0);
    issue(1, 12'h500, 8'h01, 6'd3, 0, 0, 0, "R8 replayed load not stored");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule